// File: doc/BRIEF.md
# Decompression DMA Snoop and ROM Bank Mapper

This block is a cartridge-side memory controller on the CPU address and data bus. It maps cartridge ROM into the CPU space in two ways. The low banks get fixed 32 KB windows, which can be forced to mirror. The high banks get four 1 MB windows, each chosen by a bank-select register. The controller also watches CPU writes to the DMA controller's register page. From these writes it keeps a copy of each channel's 24-bit source address and 16-bit byte count.

Software arms channels through two masks. When a high-bank read hits the stored source address of a channel that is set in both masks, the block does not return the raw ROM byte. It returns the next byte from an external decompressor, through a small handshake. The first byte of a stream starts the decompressor at the read address. When a channel's count runs out, that channel disarms itself and the next stream starts afresh.

Top module: `dcx_bus_ctrl`

## Requirements
- R1: Reads in the register window return the stored values: offset 0 is the enable mask, offset 1 is the process mask, and offsets 4 to 7 are bank selects 0 to 3. The window is offsets 0 to 7 of address 0x4800, in banks with addr[22]=0. Offsets 2 and 3, and every other address in 0x4000–0x4FFF, return `ext_reg_rdata`.
- R2: After reset both masks read 0x00, and bank selects 0 to 3 read 0x00, 0x01, 0x02 and 0x03.
- R3: A CPU write to 0x4300–0x437A uses addr[6:4] as the channel. Low nibble 2, 3 and 4 set address bytes 0, 1 and 2. Low nibble 5 and 6 set the low and high length bytes. Such a write, and any other write in 0x4000–0x4FFF outside the register window, raises `ext_reg_wr`. Writes to the register window and to ROM do not raise it.
- R4: For banks 0xC0–0xFF, `rom_page` is {select[addr[21:20]][3:0], addr[19:12]}. A read with no armed match returns the ROM byte.
- R5: For banks 0x00–0x3F and 0x80–0xBF at offsets 0x8000–0xFFFF, `rom_page` is {addr[21:16], addr[14:12]}. When bit 7 of bank select 1 (for addr[23]=0) or bank select 3 (for addr[23]=1) is set, addr[21] is taken as 0.
- R6: A channel is active when its bit is set in both the enable mask and the process mask. A high-bank read whose address equals an active channel's stored address returns decompressed data. Otherwise it returns raw ROM.
- R7: The first matching read after reset, or after a stream has ended, pulses `dec_init` with `dec_start_addr` equal to the read address. Later matching reads fetch bytes through `dec_byte_req` without a new init.
- R8: Each delivered byte lowers the matched channel's length by one. When the length reaches 0, that channel's process-mask bit clears and the next match starts a new stream.
- R9: When several active channels hold the same address, the lowest-numbered channel serves the read.
- R10: A matching read holds `cpu_wait` high until `dec_byte_valid` is seen with `dec_byte_req`. The read completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 24 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | CPU read data |
| cpu_wait | output | 1 | Stretch the current read |
| ext_reg_wr | output | 1 | Forward the write to the normal register target |
| ext_reg_rdata | input | 8 | Read data from the normal register target |
| rom_page | output | ROM_PAGE_W | 4 KB ROM page index |
| rom_offset | output | 12 | Byte offset inside the page |
| rom_data | input | 8 | ROM byte at page/offset |
| dec_init | output | 1 | Start the decompressor |
| dec_start_addr | output | 24 | Stream start address |
| dec_byte_req | output | 1 | Request the next decompressed byte |
| dec_byte_valid | input | 1 | Decompressed byte available |
| dec_byte_data | input | 8 | Decompressed byte |

## Verification
The mapping is swept over every high bank and every low ROM bank. Each sweep uses offsets at both ends of a page and in its middle, and each is repeated with all four mirror-bit settings. This separates the select-register lookup from the mirroring of addr[21]. Streams are run with several lengths:
- A three-byte stream confirms the single init and the self-disarm.
- A 258-byte stream, whose length comes from both length bytes, shows that the disarm happens on the last byte and not one byte earlier.
- Two armed channels that share an address expose the priority order.
- A channel armed in the process mask but not enabled shows that both masks are needed.

// File: rtl/dcx_pkg.sv
// Shared constants and bus region decode for the decompression bus controller.
// Assumes a 24-bit CPU address of {bank[7:0], offset[15:0]}.
package dcx_pkg;
    localparam int unsigned CPU_AW   = 24;
    localparam int unsigned NUM_SEL  = 4;
    localparam logic [12:0] REG_WIN  = 13'h0900;   // 0x4800 >> 3
    localparam logic [15:0] SNOOP_LO = 16'h4300;
    localparam logic [15:0] SNOOP_HI = 16'h437A;

    typedef enum logic [1:0] {RGN_NONE, RGN_HIROM, RGN_LOROM, RGN_REGS} region_e;

    // Classify a CPU address into the region that serves it.
    function automatic region_e classify(input logic [CPU_AW-1:0] a);
        if (a[23:22] == 2'b11)                  return RGN_HIROM;
        else if (!a[22] && a[15])               return RGN_LOROM;
        else if (!a[22] && a[15:12] == 4'h4)    return RGN_REGS;
        else                                    return RGN_NONE;
    endfunction
endpackage

// File: rtl/dcx_regs.sv
// Control register bank: enable mask, process mask and four bank selects.
// Assumes wr_en already qualifies the 0x4800-0x4807 window; offsets 2/3 unused.
module dcx_regs
    import dcx_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              off,
    input  logic [7:0]              wdata,
    input  logic [NUM_CH-1:0]       clr_mask,
    output logic [NUM_CH-1:0]       en_mask,
    output logic [NUM_CH-1:0]       proc_mask,
    output logic [NUM_SEL-1:0][7:0] sel,
    output logic [7:0]              rdata,
    output logic                    rd_hit
);
    // Enable mask: written by the CPU only.
    always_ff @(posedge clk) begin
        if (!rst_n)                    en_mask <= '0;
        else if (wr_en && off == 3'd0) en_mask <= wdata[NUM_CH-1:0];
    end

    // Process mask: CPU write, or per-channel clear at end of stream.
    always_ff @(posedge clk) begin
        if (!rst_n)                    proc_mask <= '0;
        else if (wr_en && off == 3'd1) proc_mask <= wdata[NUM_CH-1:0];
        else                           proc_mask <= proc_mask & ~clr_mask;
    end

    // Bank selects: reset to their own index.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n)                                   sel[g] <= 8'(g);
            else if (wr_en && off == 3'(4 + g))           sel[g] <= wdata;
        end
    end

    // Read-back mux for the decoded offsets.
    always_comb begin
        rd_hit = 1'b1;
        rdata  = 8'h00;
        case (off)
            3'd0: rdata = 8'(en_mask);
            3'd1: rdata = 8'(proc_mask);
            3'd4, 3'd5, 3'd6, 3'd7: rdata = sel[off[1:0]];
            default: rd_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dcx_snoop.sv
// DMA channel shadow: captures source address/length from snooped CPU writes,
// finds the lowest active channel whose address equals the lookup address,
// and counts its length down on each consumed byte.
module dcx_snoop
    import dcx_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned LEN_W  = 16,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_wr,
    input  logic [2:0]        wr_ch,
    input  logic [3:0]        wr_field,
    input  logic [7:0]        wdata,
    input  logic [CPU_AW-1:0] look_addr,
    input  logic [NUM_CH-1:0] active,
    input  logic              consume,
    output logic              hit,
    output logic [CH_W-1:0]   hit_idx,
    output logic              hit_last
);
    logic [NUM_CH-1:0][CPU_AW-1:0] src_q;
    logic [NUM_CH-1:0][LEN_W-1:0]  len_q;
    logic [NUM_CH-1:0]             eq;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel_wr;
        assign sel_wr = snoop_wr && (wr_ch == 3'(g));

        // Source address bytes captured from snooped writes.
        always_ff @(posedge clk) begin
            if (!rst_n) src_q[g] <= '0;
            else if (sel_wr) begin
                case (wr_field)
                    4'h2: src_q[g][7:0]   <= wdata;
                    4'h3: src_q[g][15:8]  <= wdata;
                    4'h4: src_q[g][23:16] <= wdata;
                    default: ;
                endcase
            end
        end

        // Length bytes from snooped writes; decrement on each delivered byte.
        always_ff @(posedge clk) begin
            if (!rst_n) len_q[g] <= '0;
            else if (sel_wr && wr_field == 4'h5) len_q[g][7:0]  <= wdata;
            else if (sel_wr && wr_field == 4'h6) len_q[g][15:8] <= wdata;
            else if (consume && hit_idx == CH_W'(g)) len_q[g] <= len_q[g] - 1'b1;
        end

        assign eq[g] = active[g] && (src_q[g] == look_addr);
    end

    // Priority pick: the lowest-numbered matching channel wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = CH_W'(i);
            end
        end
        hit_last = (len_q[hit_idx] == LEN_W'(1));
    end
endmodule

// File: rtl/dcx_rommap.sv
// ROM page translation for both the switched high banks and the fixed low
// windows, with optional forced mirroring of addr[21] in the low banks.
module dcx_rommap
    import dcx_pkg::*;
#(
    parameter int unsigned ROM_PAGE_W = 12
) (
    input  logic [CPU_AW-1:0]       addr,
    input  logic [NUM_SEL-1:0][7:0] sel,
    output logic [ROM_PAGE_W-1:0]   page
);
    logic [11:0] hi_page, lo_page, full;
    logic [7:0]  win;
    logic        mirror;

    // Build both candidate pages and pick by the bank's top bits.
    always_comb begin
        win     = sel[addr[21:20]];
        hi_page = {win[3:0], addr[19:12]};
        mirror  = addr[23] ? sel[3][7] : sel[1][7];
        lo_page = {3'b000, addr[21] & ~mirror, addr[20:16], addr[14:12]};
        full    = (addr[23:22] == 2'b11) ? hi_page : lo_page;
        page    = full[ROM_PAGE_W-1:0];
    end
endmodule

// File: rtl/dcx_bus_ctrl.sv
// Top of the decompression bus controller. Decodes CPU accesses, forwards
// register-page writes, maps ROM, and swaps in decompressed data when an
// armed DMA channel reads its source address. Assumes rom_data is valid in
// the same cycle as rom_page/rom_offset and cpu_rd/cpu_wr are exclusive.
module dcx_bus_ctrl
    import dcx_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned ROM_PAGE_W = 12,
    localparam int unsigned CH_W      = $clog2(NUM_CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [23:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    output logic [7:0]            cpu_rdata,
    output logic                  cpu_wait,
    output logic                  ext_reg_wr,
    input  logic [7:0]            ext_reg_rdata,
    output logic [ROM_PAGE_W-1:0] rom_page,
    output logic [11:0]           rom_offset,
    input  logic [7:0]            rom_data,
    output logic                  dec_init,
    output logic [23:0]           dec_start_addr,
    output logic                  dec_byte_req,
    input  logic                  dec_byte_valid,
    input  logic [7:0]            dec_byte_data
);
    region_e                  region;
    logic                     in_win, snoop_wr, match, consume, need_init;
    logic                     hit, hit_last, reg_hit;
    logic [CH_W-1:0]          hit_idx;
    logic [NUM_CH-1:0]        en_mask, proc_mask, clr_mask;
    logic [NUM_SEL-1:0][7:0]  sel;
    logic [7:0]               reg_rdata;

    assign region   = classify(cpu_addr);
    assign in_win   = (region == RGN_REGS) && (cpu_addr[15:3] == REG_WIN);
    assign snoop_wr = cpu_wr && (region == RGN_REGS) &&
                      (cpu_addr[15:0] >= SNOOP_LO) && (cpu_addr[15:0] <= SNOOP_HI);
    assign ext_reg_wr = cpu_wr && (region == RGN_REGS) && !in_win;

    dcx_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr && in_win), .off(cpu_addr[2:0]),
        .wdata(cpu_wdata), .clr_mask(clr_mask), .en_mask(en_mask),
        .proc_mask(proc_mask), .sel(sel), .rdata(reg_rdata), .rd_hit(reg_hit)
    );

    dcx_snoop #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) snoop_i (
        .clk(clk), .rst_n(rst_n), .snoop_wr(snoop_wr), .wr_ch(cpu_addr[6:4]),
        .wr_field(cpu_addr[3:0]), .wdata(cpu_wdata), .look_addr(cpu_addr),
        .active(en_mask & proc_mask), .consume(consume), .hit(hit),
        .hit_idx(hit_idx), .hit_last(hit_last)
    );

    dcx_rommap #(.ROM_PAGE_W(ROM_PAGE_W)) map_i (
        .addr(cpu_addr), .sel(sel), .page(rom_page)
    );

    assign rom_offset     = cpu_addr[11:0];
    assign match          = cpu_rd && (region == RGN_HIROM) && hit;
    assign dec_init       = match && need_init;
    assign dec_start_addr = cpu_addr;
    assign dec_byte_req   = match && !need_init;
    assign consume        = dec_byte_req && dec_byte_valid;
    assign cpu_wait       = match && !consume;
    assign clr_mask       = (consume && hit_last) ? (NUM_CH'(1) << hit_idx) : '0;

    // Stream state: cleared once the decompressor is started, set at stream end.
    always_ff @(posedge clk) begin
        if (!rst_n)                   need_init <= 1'b1;
        else if (dec_init)            need_init <= 1'b0;
        else if (consume && hit_last) need_init <= 1'b1;
    end

    // CPU read data selection by region.
    always_comb begin
        case (region)
            RGN_HIROM: cpu_rdata = match ? dec_byte_data : rom_data;
            RGN_LOROM: cpu_rdata = rom_data;
            RGN_REGS:  cpu_rdata = (in_win && reg_hit) ? reg_rdata : ext_reg_rdata;
            default:   cpu_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/dcx_bus_ctrl_chk.sv
// Property checker for dcx_bus_ctrl, attached by bind below.
module dcx_bus_ctrl_chk #(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned ROM_PAGE_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [23:0]           cpu_addr,
    input logic                  cpu_rd,
    input logic                  cpu_wr,
    input logic                  cpu_wait,
    input logic [ROM_PAGE_W-1:0] rom_page,
    input logic                  dec_init,
    input logic [23:0]           dec_start_addr,
    input logic                  dec_byte_req,
    input logic [NUM_CH-1:0]     proc_mask
);
    // R7: a stream start is never repeated in the following cycle.
    p_init_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_init |=> !dec_init);

    // R7: the decompressor starts at the address being read.
    p_init_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_init |-> (dec_start_addr == cpu_addr) && cpu_rd);

    // R6: init and byte request are never asserted together.
    p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_init && dec_byte_req));

    // R10: a stall is always tied to a pending decompressor action.
    p_wait_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (dec_init || dec_byte_req));

    // R4: high-bank page keeps addr[19:12] as its low byte.
    p_hi_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[23:22] == 2'b11) |-> (rom_page[7:0] == cpu_addr[19:12]));

    // R8: without a CPU write, process-mask bits can only clear.
    p_mask_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> ((proc_mask & ~$past(proc_mask)) == '0));
endmodule

bind dcx_bus_ctrl dcx_bus_ctrl_chk #(.NUM_CH(NUM_CH), .ROM_PAGE_W(ROM_PAGE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wait(cpu_wait), .rom_page(rom_page), .dec_init(dec_init),
    .dec_start_addr(dec_start_addr), .dec_byte_req(dec_byte_req), .proc_mask(proc_mask)
);

// File: tb/dcx_bus_ctrl_tb_top.sv
// Self-checking bench: mapping sweeps, register and snoop checks, and
// decompressed streams against a simple counting decompressor model.
module dcx_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait, ext_reg_wr;
    logic [7:0]  ext_reg_rdata = 8'hE7;
    logic [11:0] rom_page, rom_offset;
    logic [7:0]  rom_data;
    logic        dec_init, dec_byte_req, dec_byte_valid;
    logic [23:0] dec_start_addr;
    logic [7:0]  dec_byte_data;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0]  bsel [4];
    logic        dly;
    logic [7:0]  dec_cnt;
    int          init_cnt;
    logic [23:0] init_addr;
    logic        last_ext_wr;

    always #2.5 clk = ~clk;

    dcx_bus_ctrl dut_i (.*);

    // ROM model: byte is a function of page and offset.
    assign rom_data = 8'(rom_page * 7) ^ rom_offset[7:0];

    // Decompressor model: one wait cycle per byte, counting data from 0x80.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly <= 1'b0; dec_cnt <= '0; init_cnt <= 0; init_addr <= '0;
        end else begin
            dly <= dec_byte_req && !dec_byte_valid;
            if (dec_init) begin
                dec_cnt <= '0; init_cnt <= init_cnt + 1; init_addr <= dec_start_addr;
            end else if (dec_byte_req && dec_byte_valid) dec_cnt <= dec_cnt + 1'b1;
        end
    end
    assign dec_byte_valid = dec_byte_req && dly;
    assign dec_byte_data  = 8'h80 + dec_cnt;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1 last_ext_wr = ext_reg_wr;
        @(negedge clk); cpu_wr = 1'b0;
        if (a[15:0] >= 16'h4804 && a[15:0] <= 16'h4807 && !a[22]) bsel[a[1:0]] = d;
    endtask

    task automatic rd(input logic [23:0] a, output logic [7:0] d, output int waits,
                      output logic [11:0] pg);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1; waits = 0;
        #1;
        while (cpu_wait && waits < 20) begin
            @(negedge clk); #1; waits++;
        end
        d = cpu_rdata; pg = rom_page;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    function automatic logic [11:0] hi_pg(input logic [23:0] a);
        return {bsel[a[21:20]][3:0], a[19:12]};
    endfunction

    function automatic logic [11:0] lo_pg(input logic [23:0] a);
        int b, m;
        b = int'(a[23:16]);
        m = (a[23] ? bsel[3][7] : bsel[1][7]) ? 'h1F : 'h3F;
        return 12'(((b & m) << 3) | ((int'(a[15:0]) >> 12) & 7));
    endfunction

    function automatic logic [7:0] rom_b(input logic [11:0] p, input logic [23:0] a);
        return 8'(p * 7) ^ a[7:0];
    endfunction

    // Watchdog: an expired run is a failed check.
    initial begin
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d; int w; logic [11:0] pg;
        for (int i = 0; i < 4; i++) bsel[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset values.
        rd(24'h004800, d, w, pg); chk("R2 en mask", d, 8'h00);
        rd(24'h004801, d, w, pg); chk("R2 proc mask", d, 8'h00);
        for (int i = 0; i < 4; i++) begin
            rd(24'h004804 + 24'(i), d, w, pg); chk("R2 bank select", d, 8'(i));
        end

        // R1: register write/readback and fall-through reads.
        wr(24'h004800, 8'hA5); rd(24'h804800, d, w, pg); chk("R1 en mask", d, 8'hA5);
        wr(24'h004801, 8'h3C); rd(24'h004801, d, w, pg); chk("R1 proc mask", d, 8'h3C);
        wr(24'h004806, 8'h4B); rd(24'h004806, d, w, pg); chk("R1 bank select 2", d, 8'h4B);
        rd(24'h004802, d, w, pg); chk("R1 offset 2 falls through", d, 8'hE7);
        rd(24'h004803, d, w, pg); chk("R1 offset 3 falls through", d, 8'hE7);
        rd(24'h004212, d, w, pg); chk("R1 other reg falls through", d, 8'hE7);

        // R3: forwarding of writes.
        wr(24'h004305, 8'h00); chk("R3 snoop write forwarded", last_ext_wr, 1'b1);
        wr(24'h004210, 8'h00); chk("R3 other reg write forwarded", last_ext_wr, 1'b1);
        wr(24'h004804, 8'h00); chk("R3 window write not forwarded", last_ext_wr, 1'b0);
        wr(24'hC00000, 8'h77); chk("R3 ROM write not forwarded", last_ext_wr, 1'b0);
        rd(24'h004804, d, w, pg); chk("R3 ROM write changes nothing", d, 8'h00);
        wr(24'h004800, 8'h00); wr(24'h004801, 8'h00);

        // R4: high bank sweep.
        wr(24'h004804, 8'h85); wr(24'h004805, 8'h0A); wr(24'h004806, 8'h73); wr(24'h004807, 8'hFC);
        for (int b = 8'hC0; b <= 8'hFF; b++) begin
            for (int k = 0; k < 3; k++) begin
                logic [23:0] a;
                a = {8'(b), (k == 0) ? 16'h0000 : (k == 1) ? 16'h5ABC : 16'hFFFF};
                rd(a, d, w, pg);
                chk("R4 high page", pg, hi_pg(a));
                chk("R4 high raw data", d, rom_b(hi_pg(a), a));
            end
        end

        // R5: low bank sweep over all mirror settings.
        for (int m = 0; m < 4; m++) begin
            wr(24'h004805, m[0] ? 8'h8A : 8'h0A);
            wr(24'h004807, m[1] ? 8'h8C : 8'h0C);
            for (int b = 0; b < 128; b++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [23:0] a;
                    a = {(b < 64) ? 8'(b) : 8'(b + 64),
                         (k == 0) ? 16'h8000 : (k == 1) ? 16'hC123 : 16'hFFFF};
                    rd(a, d, w, pg);
                    chk("R5 low page", pg, lo_pg(a));
                    chk("R5 low data", d, rom_b(lo_pg(a), a));
                end
            end
        end
        wr(24'h004805, 8'h01); wr(24'h004807, 8'h03);

        // R6 R7 R8 R10: three-byte stream on channel 3.
        wr(24'h004332, 8'h40); wr(24'h004333, 8'h23); wr(24'h004334, 8'hC1);
        wr(24'h004335, 8'h03); wr(24'h004336, 8'h00);
        wr(24'h004800, 8'h08); wr(24'h004801, 8'h08);
        rd(24'hC12340, d, w, pg);
        chk("R6 decompressed byte 0", d, 8'h80);
        chk("R10 first byte waits", w, 2);
        chk("R7 init count", init_cnt, 1);
        chk("R7 init address", init_addr, 24'hC12340);
        rd(24'hC12341, d, w, pg); chk("R6 non-matching read raw", d, rom_b(hi_pg(24'hC12341), 24'hC12341));
        rd(24'hC12340, d, w, pg);
        chk("R6 decompressed byte 1", d, 8'h81);
        chk("R10 later byte waits", w, 1);
        chk("R7 no second init", init_cnt, 1);
        rd(24'h004801, d, w, pg); chk("R8 still armed", d, 8'h08);
        rd(24'hC12340, d, w, pg); chk("R6 decompressed byte 2", d, 8'h82);
        rd(24'h004801, d, w, pg); chk("R8 disarmed at zero", d, 8'h00);
        rd(24'hC12340, d, w, pg); chk("R6 raw after disarm", d, rom_b(hi_pg(24'hC12340), 24'hC12340));

        // R6: process set but enable clear gives raw ROM.
        wr(24'h004322, 8'h00); wr(24'h004323, 8'h00); wr(24'h004324, 8'hE0);
        wr(24'h004325, 8'h05); wr(24'h004326, 8'h00);
        wr(24'h004800, 8'h00); wr(24'h004801, 8'h04);
        rd(24'hE00000, d, w, pg); chk("R6 not enabled gives raw", d, rom_b(hi_pg(24'hE00000), 24'hE00000));
        rd(24'h004801, d, w, pg); chk("R6 not enabled untouched", d, 8'h04);

        // R9: shared address on channels 1 and 5.
        wr(24'h004312, 8'h10); wr(24'h004313, 8'h00); wr(24'h004314, 8'hD0);
        wr(24'h004315, 8'h01); wr(24'h004316, 8'h00);
        wr(24'h004352, 8'h10); wr(24'h004353, 8'h00); wr(24'h004354, 8'hD0);
        wr(24'h004355, 8'h01); wr(24'h004356, 8'h00);
        wr(24'h004800, 8'h22); wr(24'h004801, 8'h22);
        rd(24'hD00010, d, w, pg); chk("R9 first read decompressed", d, 8'h80);
        rd(24'h004801, d, w, pg); chk("R9 lowest channel served", d, 8'h20);
        rd(24'hD00010, d, w, pg); chk("R9 next channel new stream", d, 8'h80);
        chk("R8 re-init after stream end", init_cnt, 3);
        rd(24'h004801, d, w, pg); chk("R9 both disarmed", d, 8'h00);

        // R3 R8: 258-byte stream on channel 0 built from both length bytes.
        wr(24'h004302, 8'h12); wr(24'h004303, 8'h34); wr(24'h004304, 8'hC5);
        wr(24'h004305, 8'h02); wr(24'h004306, 8'h01);
        wr(24'h004800, 8'h01); wr(24'h004801, 8'h01);
        for (int k = 0; k < 257; k++) begin
            rd(24'hC53412, d, w, pg);
            chk("R3 long stream byte", d, 8'(8'h80 + k));
        end
        rd(24'h004801, d, w, pg); chk("R8 armed before last byte", d, 8'h01);
        rd(24'hC53412, d, w, pg); chk("R8 last byte", d, 8'h81);
        rd(24'h004801, d, w, pg); chk("R8 disarmed after last byte", d, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule